// File: doc/BRIEF.md
# Cycle, Time and Retired-Instruction Counter Block

This block keeps three free-running event counters for a processor core, each twice as wide as the data path. The first counts core clock cycles. The second counts pulses of a real-time tick input. The third counts retired instructions, one for each cycle in which the retire pulse is high. Software reads each counter 32 bits at a time. The low half and the high half of each counter have their own CSR addresses, so a 64-bit value is read in two accesses.

The retired-instruction counter can also be written, one half at a time. If a write and a retirement fall in the same cycle, the retirement increment is applied first and the written half then replaces its part of the incremented value. A read returns the count as it stood before the current cycle's increment.

A carry out of the low half reaches the high half in the same clock edge as the low-half wrap. Software can therefore read high, low and high again, and retry the read when the two high values differ.

Top module: `perf_ctr_csr`

## Requirements
- R1: While the reset input is low, every counter is zero, and a read of any of the six counter addresses returns zero.
- R2: The cycle counter increases by exactly one on every clock edge after reset is released.
- R3: The time counter increases by one on each edge where tick_i is high, and holds its value otherwise.
- R4: The retired-instruction counter increases by one on each edge where retire_i is high, and holds its value otherwise (unless written).
- R5: Addresses 0xC00, 0xC01 and 0xC02 read bits [DATA_W-1:0] of cycle, time and retired-instruction counters; 0xC80, 0xC81 and 0xC82 read bits [2*DATA_W-1:DATA_W] of the same counters.
- R6: Read data is combinational from the counter registers, so a read in a cycle with retire_i high returns the value before that cycle's increment.
- R7: A write to 0xC02 or 0xC82 with retire_i high applies the increment first and then replaces the addressed half with csr_wdata_i. The next read of that half returns exactly the written value, and the other half keeps its incremented value.
- R8: When a counter's low half wraps from all ones to zero, its high half increases by one on the same clock edge.
- R9: A write to any cycle or time address raises csr_illegal_o in that cycle and leaves that counter unchanged. A write to a retired-instruction address does not raise csr_illegal_o.
- R10: A read or write to an address outside the six counter addresses raises csr_illegal_o, and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Real-time tick pulse, one count per high cycle |
| retire_i | input | 1 | Instruction retired in this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_rd_i | input | 1 | CSR read strobe |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | DATA_W | CSR write data |
| csr_rdata_o | output | DATA_W | CSR read data, counter value before this cycle's update |
| csr_illegal_o | output | 1 | Access to an unmapped address, or write to a read-only counter |

## Verification
The bench builds the block with DATA_W set to 8, so each counter is 16 bits wide. The low half of the cycle counter then wraps every 256 clocks, which puts the same-edge carry and the high-low-high rollover read within a few hundred cycles of reset. The same narrow width also lets directed writes park the retired-instruction counter just below a wrap, so the carry can be combined with a same-cycle write to either half. Random ticks, retirements, reads, writes and stray addresses then run over several full wraps of each low half.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  localparam int unsigned CSR_ADDR_W = 12;
  localparam int unsigned NUM_CTR    = 3;
  localparam int unsigned CTR_IDX_W  = $clog2(NUM_CTR);

  typedef enum logic [CTR_IDX_W-1:0] {
    CTR_CYCLE   = 2'd0,
    CTR_TIME    = 2'd1,
    CTR_INSTRET = 2'd2
  } ctr_id_e;

  localparam logic [CSR_ADDR_W-1:0] LO_BASE = 12'hC00;
  localparam logic [CSR_ADDR_W-1:0] HI_BASE = 12'hC80;

  localparam logic [CSR_ADDR_W-1:0] ADDR_CYCLE_LO   = LO_BASE + 12'd0;
  localparam logic [CSR_ADDR_W-1:0] ADDR_TIME_LO    = LO_BASE + 12'd1;
  localparam logic [CSR_ADDR_W-1:0] ADDR_INSTRET_LO = LO_BASE + 12'd2;
  localparam logic [CSR_ADDR_W-1:0] ADDR_CYCLE_HI   = HI_BASE + 12'd0;
  localparam logic [CSR_ADDR_W-1:0] ADDR_TIME_HI    = HI_BASE + 12'd1;
  localparam logic [CSR_ADDR_W-1:0] ADDR_INSTRET_HI = HI_BASE + 12'd2;

  // counters that accept software writes, one bit per counter id
  localparam logic [NUM_CTR-1:0] WRITABLE_MASK = 3'b100;

endpackage

// File: rtl/perf_rst_sync.sv
module perf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/perf_split_ctr.sv
module perf_split_ctr #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);

  logic [HALF_W-1:0] lo_q, hi_q;
  logic [HALF_W-1:0] lo_d, hi_d;
  logic [HALF_W-1:0] lo_inc, hi_inc;
  logic              carry;
  logic              en;

  // increment first, then let a write replace its half
  always_comb begin
    carry  = inc_i & (&lo_q);
    lo_inc = lo_q + {{(HALF_W-1){1'b0}}, inc_i};
    hi_inc = hi_q + {{(HALF_W-1){1'b0}}, carry};
    lo_d   = wr_lo_i ? wdata_i : lo_inc;
    hi_d   = wr_hi_i ? wdata_i : hi_inc;
    en     = inc_i | wr_lo_i | wr_hi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R8
  carry_same_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_lo_i && !wr_hi_i && (&lo_q)) |=>
      (lo_q == '0 && hi_q == $past(hi_q) + 1'b1));

  // R2
  low_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_lo_i && !wr_hi_i && !(&lo_q)) |=>
      (lo_q == $past(lo_q) + 1'b1 && $stable(hi_q)));

  // R3 R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/perf_csr_decode.sv
module perf_csr_decode
  import perf_ctr_pkg::*;
(
  input  logic [CSR_ADDR_W-1:0] addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  output logic                  hit_o,
  output logic [CTR_IDX_W-1:0]  idx_o,
  output logic                  hi_o,
  output logic [NUM_CTR-1:0]    wr_lo_o,
  output logic [NUM_CTR-1:0]    wr_hi_o,
  output logic                  illegal_o
);

  logic [NUM_CTR-1:0] match_lo;
  logic [NUM_CTR-1:0] match_hi;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_match
    assign match_lo[g] = (addr_i == LO_BASE + CSR_ADDR_W'(g));
    assign match_hi[g] = (addr_i == HI_BASE + CSR_ADDR_W'(g));
    assign wr_lo_o[g]  = wr_i & match_lo[g] & WRITABLE_MASK[g];
    assign wr_hi_o[g]  = wr_i & match_hi[g] & WRITABLE_MASK[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (match_lo[i] || match_hi[i]) begin
        idx_o = CTR_IDX_W'(i);
      end
    end
  end

  logic writable_sel;

  always_comb begin
    hit_o        = |{match_lo, match_hi};
    hi_o         = |match_hi;
    writable_sel = |((match_lo | match_hi) & WRITABLE_MASK);
    illegal_o    = ((rd_i | wr_i) & ~hit_o) | (wr_i & hit_o & ~writable_sel);
  end

endmodule

// File: rtl/perf_ctr_csr.sv
module perf_ctr_csr
  import perf_ctr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  retire_i,
  input  logic [CSR_ADDR_W-1:0] csr_addr_i,
  input  logic                  csr_rd_i,
  input  logic                  csr_wr_i,
  input  logic [DATA_W-1:0]     csr_wdata_i,
  output logic [DATA_W-1:0]     csr_rdata_o,
  output logic                  csr_illegal_o
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic rst_sync_n;

  perf_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  logic                 dec_hit;
  logic [CTR_IDX_W-1:0] dec_idx;
  logic                 dec_hi;
  logic [NUM_CTR-1:0]   dec_wr_lo;
  logic [NUM_CTR-1:0]   dec_wr_hi;
  logic                 dec_illegal;

  perf_csr_decode u_decode (
    .addr_i    (csr_addr_i),
    .rd_i      (csr_rd_i),
    .wr_i      (csr_wr_i),
    .hit_o     (dec_hit),
    .idx_o     (dec_idx),
    .hi_o      (dec_hi),
    .wr_lo_o   (dec_wr_lo),
    .wr_hi_o   (dec_wr_hi),
    .illegal_o (dec_illegal)
  );

  logic [NUM_CTR-1:0] ctr_inc;
  logic [DATA_W-1:0]  ctr_lo [NUM_CTR];
  logic [DATA_W-1:0]  ctr_hi [NUM_CTR];

  always_comb begin
    ctr_inc              = '0;
    ctr_inc[CTR_CYCLE]   = 1'b1;
    ctr_inc[CTR_TIME]    = tick_i;
    ctr_inc[CTR_INSTRET] = retire_i;
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    perf_split_ctr #(.HALF_W(DATA_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .inc_i   (ctr_inc[g]),
      .wr_lo_i (dec_wr_lo[g]),
      .wr_hi_i (dec_wr_hi[g]),
      .wdata_i (csr_wdata_i),
      .lo_o    (ctr_lo[g]),
      .hi_o    (ctr_hi[g])
    );
  end

  // read data reflects the registers, i.e. the value before this cycle's update
  always_comb begin
    csr_rdata_o = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (csr_rd_i && dec_hit && dec_idx == CTR_IDX_W'(i)) begin
        csr_rdata_o = dec_hi ? ctr_hi[i] : ctr_lo[i];
      end
    end
  end

  assign csr_illegal_o = dec_illegal;

  logic [CNT_W-1:0] cycle_full;
  assign cycle_full = {ctr_hi[CTR_CYCLE], ctr_lo[CTR_CYCLE]};

  // R9
  ro_write_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (csr_wr_i && (csr_addr_i == ADDR_CYCLE_LO || csr_addr_i == ADDR_CYCLE_HI ||
                  csr_addr_i == ADDR_TIME_LO  || csr_addr_i == ADDR_TIME_HI))
      |-> csr_illegal_o);

  // R2
  cycle_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    1'b1 |=> cycle_full == $past(cycle_full) + 1'b1);

  // R7
  instret_lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (csr_wr_i && csr_addr_i == ADDR_INSTRET_LO) |=>
      ctr_lo[CTR_INSTRET] == $past(csr_wdata_i));

  // R7
  instret_hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (csr_wr_i && csr_addr_i == ADDR_INSTRET_HI) |=>
      ctr_hi[CTR_INSTRET] == $past(csr_wdata_i));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (csr_rd_i && !dec_hit) |-> (csr_rdata_o == '0 && csr_illegal_o));

endmodule

// File: tb/perf_ctr_csr_test.sv
module perf_ctr_csr_test;

  localparam int DW = 8;
  localparam int CW = 2 * DW;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          retire;
  logic [11:0]   addr;
  logic          rd;
  logic          wr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          illegal;

  int checks   = 0;
  int failures = 0;

  logic [CW-1:0] m_cyc;
  logic [CW-1:0] m_tm;
  logic [CW-1:0] m_ir;

  perf_ctr_csr #(.DATA_W(DW)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .retire_i      (retire),
    .csr_addr_i    (addr),
    .csr_rd_i      (rd),
    .csr_wr_i      (wr),
    .csr_wdata_i   (wdata),
    .csr_rdata_o   (rdata),
    .csr_illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic is_mapped(input logic [11:0] a);
    return (a == 12'hC00 || a == 12'hC01 || a == 12'hC02 ||
            a == 12'hC80 || a == 12'hC81 || a == 12'hC82);
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [11:0] a);
    case (a)
      12'hC00: return m_cyc[DW-1:0];
      12'hC80: return m_cyc[CW-1:DW];
      12'hC01: return m_tm[DW-1:0];
      12'hC81: return m_tm[CW-1:DW];
      12'hC02: return m_ir[DW-1:0];
      12'hC82: return m_ir[CW-1:DW];
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_illegal(input logic [11:0] a, input logic r, input logic w);
    if ((r || w) && !is_mapped(a)) return 1'b1;
    if (w && a != 12'hC02 && a != 12'hC82) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one clock: drive at negedge, check the combinational outputs, advance the model
  task automatic step(input logic tk, input logic rt, input logic r, input logic w,
                      input logic [11:0] a, input logic [DW-1:0] wd, input string req);
    logic [CW-1:0] v;
    @(negedge clk);
    tick = tk; retire = rt; rd = r; wr = w; addr = a; wdata = wd;
    #1;
    if (r) check(req, 32'(rdata), 32'(exp_read(a)));
    check(is_mapped(a) ? "R9" : "R10", 32'(illegal), 32'(exp_illegal(a, r, w)));
    m_cyc = m_cyc + 1'b1;
    if (tk) m_tm = m_tm + 1'b1;
    v = m_ir + CW'(rt);
    if (w && a == 12'hC02) v[DW-1:0]  = wd;
    if (w && a == 12'hC82) v[CW-1:DW] = wd;
    m_ir = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 12'hC00, '0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] rd_map [6];
    void'($urandom(32'd20240611));
    rd_map[0] = 12'hC00; rd_map[1] = 12'hC01; rd_map[2] = 12'hC02;
    rd_map[3] = 12'hC80; rd_map[4] = 12'hC81; rd_map[5] = 12'hC82;
    m_cyc = '0; m_tm = '0; m_ir = '0;
    rst_n = 1'b0; tick = 1'b0; retire = 1'b0; rd = 1'b0; wr = 1'b0;
    addr = 12'hC00; wdata = '0;

    // R1: every address reads zero while reset is held, even with activity
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tick = 1'b1; retire = 1'b1; rd = 1'b1; addr = rd_map[i];
      #1;
      check("R1", 32'(rdata), 32'h0);
    end
    @(negedge clk);
    tick = 1'b0; retire = 1'b0; rd = 1'b0;
    rst_n = 1'b1;
    idle(4);

    // R2: baseline of the cycle counter, then it is tracked cycle by cycle
    @(negedge clk);
    rd = 1'b1; addr = 12'hC00;
    #1;
    check("R2", 32'((rdata >= 1) && (rdata <= 8)), 32'h1);
    m_cyc = CW'(rdata) + 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC80, '0, "R5");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC00, '0, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC00, '0, "R2");

    // R3: ticks advance the time counter, gaps hold it
    step(1'b1, 1'b0, 1'b1, 1'b0, 12'hC01, '0, "R3");
    step(1'b1, 1'b0, 1'b1, 1'b0, 12'hC01, '0, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC01, '0, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC01, '0, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC81, '0, "R5");

    // R4 R6: read during retire returns the pre-increment value
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'hC02, 8'h10, "R7");
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'hC02, '0, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC02, '0, "R4");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC02, '0, "R4");

    // R7: write and retire in the same cycle, write lands after the increment
    step(1'b0, 1'b1, 1'b0, 1'b1, 12'hC02, 8'h40, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC02, '0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'hC02, 8'hFF, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b1, 12'hC82, 8'h05, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC02, '0, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC82, '0, "R7");

    // R8: retired-instruction low half wraps, high half follows on the same edge
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'hC02, 8'hFF, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'hC82, 8'h03, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC82, '0, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'hC02, '0, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC82, '0, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC02, '0, "R8");

    // R8: high-low-high read of the cycle counter across a low-half wrap
    while (m_cyc[DW-1:0] != 8'hFE) step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC00, '0, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC80, '0, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC00, '0, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC80, '0, "R8");

    // R9: writes to read-only counters flagged and ignored
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'hC00, 8'hAA, "R9");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC00, '0, "R9");
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'hC81, 8'h55, "R9");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC81, '0, "R9");

    // R10: unmapped addresses
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC03, '0, "R10");
    step(1'b0, 1'b0, 1'b1, 1'b0, 12'hC83, '0, "R10");
    step(1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 8'h11, "R10");

    // random mix over several wraps
    for (int n = 0; n < 3000; n++) begin
      logic          tk, rt;
      logic [11:0]   a;
      int unsigned   op;
      tk = ($urandom % 3) == 0;
      rt = $urandom % 2;
      op = $urandom % 10;
      if (op < 7) begin
        step(tk, rt, 1'b1, 1'b0, rd_map[$urandom % 6], '0, "R5");
      end else if (op == 7) begin
        a = ($urandom % 2) ? 12'hC02 : 12'hC82;
        step(tk, rt, $urandom % 2, 1'b1, a, 8'($urandom), "R7");
      end else if (op == 8) begin
        a = rd_map[$urandom % 2 + (($urandom % 2) ? 3 : 0)];
        step(tk, rt, 1'b0, 1'b1, a, 8'($urandom), "R9");
      end else begin
        case ($urandom % 4)
          0: a = 12'hC03;
          1: a = 12'hC83;
          2: a = 12'hC40;
          default: a = 12'hFFF;
        endcase
        step(tk, rt, 1'b1, $urandom % 2, a, 8'($urandom), "R10");
      end
    end
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1, 1'b0, rd_map[i], '0, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule